// File: doc/BRIEF.md
# Trap Entry Controller

This block works out the full architectural state change that a small 32-bit soft processor makes when it enters a trap. The pipeline presents four cause lines: memory-translation fault, hardware exception, hardware break and external interrupt. Alongside them it presents the current program counter, status word, exception status word, the instruction-context flags (delay slot, immediate prefix, branch-with-immediate), the pending branch target and the faulting address. A vector base input sets where all the trap vectors sit.

One cycle after a cause is granted, the block raises `take_o` for one cycle. In that same cycle it presents the redirect address, the new status word, a link-register write, and the exception-status, branch-target and fault-address writes. It also gives pulses that clear the instruction flags and the load-reserve reservation. It decides whether a pending external interrupt may be taken and confirms that decision with `irq_ack_o`. The pipeline commits all the writes in the cycle `take_o` is high.

Top module: `trap_entry_ctrl`

## Requirements
- R1: One cycle after a cause is granted, `take_o` is high and `pc_o` holds `vec_base_i` plus an offset. The offset is 0x10 for an external interrupt, 0x18 for a break, and 0x20 for a hardware exception or a translation fault.
- R2: The link write targets register 14 with the PC for an interrupt and register 16 with the PC for a break. For a hardware exception it targets register 17 with PC+4.
- R3: For a translation fault, register 17 gets a value that depends on the flags. In a delay slot it gets PC-8 when the branch-with-immediate flag is set, and PC-4 when it is not. Outside a delay slot it gets PC-4 after an immediate prefix, and the PC otherwise.
- R4: The status word changes by cause. An interrupt clears bit 1 (interrupt enable). A break sets bit 3 (break in progress). Both exception causes set bit 9 (exception in progress).
- R5: On every entry, bit 13 (virtual mode) is copied to bit 14 and bit 11 (user mode) is copied to bit 12. Bits 13 and 11 are then cleared. All other bits are kept unless R4 changes them.
- R6: For both exception causes, bit 12 of the exception status equals the delay-slot flag. The branch-target register is written with the branch target only when the delay-slot flag is set. For a hardware exception, the other exception status bits come from `esr_i`.
- R7: For a translation fault, exception status bits [4:0] hold a code. The code is 17 for a fetch protection fault, 16 for a data protection fault, 19 for a fetch miss and 18 for a data miss. Bit 10 is set for a store. The fault address is written to the fault-address register.
- R8: An external interrupt is taken only when all of these hold: status bit 1 is set, status bits 9 and 3 are clear, and neither the delay-slot flag nor the immediate-prefix flag is set. `irq_ack_o` marks that entry.
- R9: When several causes are raised together, the first one in this order wins: translation fault, hardware exception, break, interrupt.
- R10: While `cfg_exc_en_i` is low, a hardware exception request is ignored. If no other cause is raised, no entry happens. Otherwise the next cause in priority order is taken.
- R11: Every entry pulses `resv_clr_o` and `iflags_clr_o` together with `take_o`. A cycle without a grant leaves all write enables, `take_o` and the pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vec_base_i | input | 32 | Vector base address |
| cfg_exc_en_i | input | 1 | Hardware exceptions implemented |
| mmu_fault_i | input | 1 | Translation fault cause |
| hw_exc_i | input | 1 | Hardware exception cause |
| hw_brk_i | input | 1 | Hardware break cause |
| irq_i | input | 1 | External interrupt pending |
| pc_i | input | 32 | Current PC |
| msr_i | input | 32 | Current status word |
| esr_i | input | 32 | Current exception status |
| ds_i | input | 1 | Delay-slot flag |
| imm_i | input | 1 | Immediate-prefix flag |
| bimm_i | input | 1 | Branch-with-immediate flag |
| btarget_i | input | 32 | Pending branch target |
| fault_addr_i | input | 32 | Faulting address |
| mmu_ifetch_i | input | 1 | Fault was on instruction fetch |
| mmu_miss_i | input | 1 | Fault was a miss (0: protection) |
| mmu_store_i | input | 1 | Fault access was a store |
| take_o | output | 1 | Trap entry this cycle |
| irq_ack_o | output | 1 | Entry is an accepted interrupt |
| pc_o | output | 32 | Redirect address |
| msr_o | output | 32 | New status word |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link register value |
| esr_we_o | output | 1 | Exception status write enable |
| esr_o | output | 32 | New exception status |
| btr_we_o | output | 1 | Branch-target register write enable |
| btr_o | output | 32 | Branch-target value |
| ear_we_o | output | 1 | Fault-address register write enable |
| ear_o | output | 32 | Fault-address value |
| resv_clr_o | output | 1 | Invalidate load reservation |
| iflags_clr_o | output | 1 | Clear instruction flags |

## Verification
The assertions assume a few things about the inputs. A delay-slot instruction never carries an immediate prefix. The branch-with-immediate flag is only set inside a delay slot. A translation fault flagged as a fetch is never also flagged as a store. The stimulus keeps to these rules. It presents one set of inputs per cycle and lowers all cause lines between groups of cases, so every expected entry follows from a single cycle's inputs.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XW = 32;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_MMU  = 3'd1,
    C_HWX  = 3'd2,
    C_BRK  = 3'd3,
    C_IRQ  = 3'd4
  } cause_e;

  localparam int unsigned MSR_IE  = 1;
  localparam int unsigned MSR_BIP = 3;
  localparam int unsigned MSR_EIP = 9;
  localparam int unsigned MSR_UM  = 11;
  localparam int unsigned MSR_UMS = 12;
  localparam int unsigned MSR_VM  = 13;
  localparam int unsigned MSR_VMS = 14;

  localparam int unsigned ESR_ST  = 10;
  localparam int unsigned ESR_DS  = 12;

  localparam logic [XW-1:0] OFF_IRQ = 32'h10;
  localparam logic [XW-1:0] OFF_BRK = 32'h18;
  localparam logic [XW-1:0] OFF_EXC = 32'h20;

  localparam logic [4:0] LNK_IRQ = 5'd14;
  localparam logic [4:0] LNK_BRK = 5'd16;
  localparam logic [4:0] LNK_EXC = 5'd17;

  function automatic logic [XW-1:0] push_modes(input logic [XW-1:0] m);
    logic [XW-1:0] r;
    r = m;
    r[MSR_UMS] = m[MSR_UM];
    r[MSR_VMS] = m[MSR_VM];
    r[MSR_UM]  = 1'b0;
    r[MSR_VM]  = 1'b0;
    return r;
  endfunction

  function automatic logic [XW-1:0] mmu_ret_addr(input logic [XW-1:0] pc,
                                                 input logic ds, input logic imm,
                                                 input logic bimm);
    logic [XW-1:0] back;
    if (ds)       back = bimm ? 32'd8 : 32'd4;
    else if (imm) back = 32'd4;
    else          back = 32'd0;
    return pc - back;
  endfunction

  function automatic logic [XW-1:0] mmu_esr(input logic ifetch, input logic miss,
                                            input logic store, input logic ds);
    logic [XW-1:0] r;
    r = '0;
    r[4:0]   = {3'b100, miss, ifetch};
    r[ESR_ST] = store;
    r[ESR_DS] = ds;
    return r;
  endfunction

  function automatic logic [XW-1:0] hwx_esr(input logic [XW-1:0] cur, input logic ds);
    logic [XW-1:0] r;
    r = cur;
    r[ESR_DS] = ds;
    return r;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mmu_i,
  input  logic          hwx_i,
  input  logic          brk_i,
  input  logic          irq_i,
  input  logic          exc_en_i,
  input  logic [XW-1:0] msr_i,
  input  logic          ds_i,
  input  logic          imm_i,
  output cause_e        cause_o,
  output logic          irq_ok_o
);
  logic       hwx_live;
  logic [3:0] grant;

  assign hwx_live = hwx_i & exc_en_i;
  assign irq_ok_o = irq_i & msr_i[MSR_IE] & ~msr_i[MSR_EIP] & ~msr_i[MSR_BIP]
                    & ~ds_i & ~imm_i;

  always_comb begin
    grant   = 4'b0000;
    cause_o = C_NONE;
    if (mmu_i) begin
      grant[0] = 1'b1; cause_o = C_MMU;
    end else if (hwx_live) begin
      grant[1] = 1'b1; cause_o = C_HWX;
    end else if (brk_i) begin
      grant[2] = 1'b1; cause_o = C_BRK;
    end else if (irq_ok_o) begin
      grant[3] = 1'b1; cause_o = C_IRQ;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9
  AST_MMU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_i |-> cause_o == C_MMU); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == C_IRQ) |-> (msr_i[MSR_IE] && !msr_i[MSR_EIP] && !msr_i[MSR_BIP] && !ds_i && !imm_i)); // R8
  AST_HWX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_en_i |-> cause_o != C_HWX); // R10
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cause_e        cause_i,
  input  logic [XW-1:0] vec_base_i,
  input  logic [XW-1:0] pc_i,
  input  logic          ds_i,
  input  logic          imm_i,
  input  logic          bimm_i,
  output logic [XW-1:0] new_pc_o,
  output logic          link_we_o,
  output logic [4:0]    link_idx_o,
  output logic [XW-1:0] link_val_o
);
  logic [XW-1:0] vec_off;

  always_comb begin
    vec_off    = '0;
    link_we_o  = 1'b1;
    link_idx_o = 5'd0;
    link_val_o = pc_i;
    unique case (cause_i)
      C_MMU: begin
        vec_off    = OFF_EXC;
        link_idx_o = LNK_EXC;
        link_val_o = mmu_ret_addr(pc_i, ds_i, imm_i, bimm_i);
      end
      C_HWX: begin
        vec_off    = OFF_EXC;
        link_idx_o = LNK_EXC;
        link_val_o = pc_i + 32'd4;
      end
      C_BRK: begin
        vec_off    = OFF_BRK;
        link_idx_o = LNK_BRK;
      end
      C_IRQ: begin
        vec_off    = OFF_IRQ;
        link_idx_o = LNK_IRQ;
      end
      default: link_we_o = 1'b0;
    endcase
    new_pc_o = vec_base_i + vec_off;
  end

  AST_LINK_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_idx_o == 5'd14 || link_idx_o == 5'd16 || link_idx_o == 5'd17)); // R2
  AST_MMU_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i == C_MMU && !ds_i && !imm_i) |-> link_val_o == pc_i); // R3
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cause_e        cause_i,
  input  logic [XW-1:0] msr_i,
  input  logic [XW-1:0] esr_i,
  input  logic          ds_i,
  input  logic [XW-1:0] btarget_i,
  input  logic [XW-1:0] fault_addr_i,
  input  logic          mmu_ifetch_i,
  input  logic          mmu_miss_i,
  input  logic          mmu_store_i,
  output logic [XW-1:0] msr_o,
  output logic          esr_we_o,
  output logic [XW-1:0] esr_o,
  output logic          btr_we_o,
  output logic [XW-1:0] btr_o,
  output logic          ear_we_o,
  output logic [XW-1:0] ear_o
);
  logic [XW-1:0] msr_cause;
  logic          is_exc;

  assign is_exc = (cause_i == C_MMU) || (cause_i == C_HWX);

  always_comb begin
    msr_cause = msr_i;
    unique case (cause_i)
      C_MMU, C_HWX: msr_cause[MSR_EIP] = 1'b1;
      C_BRK:        msr_cause[MSR_BIP] = 1'b1;
      C_IRQ:        msr_cause[MSR_IE]  = 1'b0;
      default:      msr_cause = msr_i;
    endcase
    msr_o = push_modes(msr_cause);
  end

  always_comb begin
    esr_we_o = is_exc;
    esr_o    = (cause_i == C_MMU) ? mmu_esr(mmu_ifetch_i, mmu_miss_i, mmu_store_i, ds_i)
                                  : hwx_esr(esr_i, ds_i);
    btr_we_o = is_exc & ds_i;
    btr_o    = btarget_i;
    ear_we_o = (cause_i == C_MMU);
    ear_o    = fault_addr_i;
  end

  AST_BTR_ONLY_DS: assert property (@(posedge clk) disable iff (!rst_n)
    btr_we_o |-> (ds_i && esr_we_o)); // R6
  AST_ESR_DS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    esr_we_o |-> esr_o[ESR_DS] == ds_i); // R6
  AST_FETCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ear_we_o && mmu_ifetch_i) |-> !esr_o[ESR_ST]); // R7
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] vec_base_i,
  input  logic        cfg_exc_en_i,
  input  logic        mmu_fault_i,
  input  logic        hw_exc_i,
  input  logic        hw_brk_i,
  input  logic        irq_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] esr_i,
  input  logic        ds_i,
  input  logic        imm_i,
  input  logic        bimm_i,
  input  logic [31:0] btarget_i,
  input  logic [31:0] fault_addr_i,
  input  logic        mmu_ifetch_i,
  input  logic        mmu_miss_i,
  input  logic        mmu_store_i,
  output logic        take_o,
  output logic        irq_ack_o,
  output logic [31:0] pc_o,
  output logic [31:0] msr_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_val_o,
  output logic        esr_we_o,
  output logic [31:0] esr_o,
  output logic        btr_we_o,
  output logic [31:0] btr_o,
  output logic        ear_we_o,
  output logic [31:0] ear_o,
  output logic        resv_clr_o,
  output logic        iflags_clr_o
);
  cause_e        cause;
  logic          irq_ok;
  logic          granted;
  logic [XW-1:0] nx_pc, nx_msr, nx_link, nx_esr, nx_btr, nx_ear;
  logic [4:0]    nx_lidx;
  logic          nx_lwe, nx_ewe, nx_bwe, nx_awe;

  trap_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .mmu_i(mmu_fault_i), .hwx_i(hw_exc_i), .brk_i(hw_brk_i), .irq_i(irq_i),
    .exc_en_i(cfg_exc_en_i), .msr_i(msr_i), .ds_i(ds_i), .imm_i(imm_i),
    .cause_o(cause), .irq_ok_o(irq_ok)
  );

  trap_target u_tgt (
    .clk(clk), .rst_n(rst_n),
    .cause_i(cause), .vec_base_i(vec_base_i), .pc_i(pc_i),
    .ds_i(ds_i), .imm_i(imm_i), .bimm_i(bimm_i),
    .new_pc_o(nx_pc), .link_we_o(nx_lwe), .link_idx_o(nx_lidx), .link_val_o(nx_link)
  );

  trap_status u_sts (
    .clk(clk), .rst_n(rst_n),
    .cause_i(cause), .msr_i(msr_i), .esr_i(esr_i), .ds_i(ds_i),
    .btarget_i(btarget_i), .fault_addr_i(fault_addr_i),
    .mmu_ifetch_i(mmu_ifetch_i), .mmu_miss_i(mmu_miss_i), .mmu_store_i(mmu_store_i),
    .msr_o(nx_msr), .esr_we_o(nx_ewe), .esr_o(nx_esr),
    .btr_we_o(nx_bwe), .btr_o(nx_btr), .ear_we_o(nx_awe), .ear_o(nx_ear)
  );

  assign granted = (cause != C_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o       <= 1'b0;
      irq_ack_o    <= 1'b0;
      link_we_o    <= 1'b0;
      esr_we_o     <= 1'b0;
      btr_we_o     <= 1'b0;
      ear_we_o     <= 1'b0;
      resv_clr_o   <= 1'b0;
      iflags_clr_o <= 1'b0;
      pc_o         <= '0;
      msr_o        <= '0;
      link_idx_o   <= '0;
      link_val_o   <= '0;
      esr_o        <= '0;
      btr_o        <= '0;
      ear_o        <= '0;
    end else begin
      take_o       <= granted;
      irq_ack_o    <= (cause == C_IRQ);
      link_we_o    <= nx_lwe;
      esr_we_o     <= nx_ewe;
      btr_we_o     <= nx_bwe;
      ear_we_o     <= nx_awe;
      resv_clr_o   <= granted;
      iflags_clr_o <= granted;
      pc_o         <= nx_pc;
      msr_o        <= nx_msr;
      link_idx_o   <= nx_lidx;
      link_val_o   <= nx_link;
      esr_o        <= nx_esr;
      btr_o        <= nx_btr;
      ear_o        <= nx_ear;
    end
  end

  AST_TAKE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    granted |=> take_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !granted |=> !(take_o || link_we_o || esr_we_o || btr_we_o || ear_we_o || resv_clr_o)); // R11
  AST_MODES_LIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!msr_o[MSR_UM] && !msr_o[MSR_VM])); // R5
  AST_ACK_IMPLIES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (take_o && link_idx_o == 5'd14)); // R8
endmodule

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] vec_base, pc, msr, esr, btarget, faddr;
  logic        exc_en, mmu, hwx, brk, irq, ds, imm, bimm, ifetch, miss, store;
  logic        take, ack, lwe, ewe, bwe, awe, rclr, fclr;
  logic [31:0] pc_o, msr_o, lval, esr_o, btr_o, ear_o;
  logic [4:0]  lidx;

  trap_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .vec_base_i(vec_base), .cfg_exc_en_i(exc_en),
    .mmu_fault_i(mmu), .hw_exc_i(hwx), .hw_brk_i(brk), .irq_i(irq),
    .pc_i(pc), .msr_i(msr), .esr_i(esr), .ds_i(ds), .imm_i(imm), .bimm_i(bimm),
    .btarget_i(btarget), .fault_addr_i(faddr),
    .mmu_ifetch_i(ifetch), .mmu_miss_i(miss), .mmu_store_i(store),
    .take_o(take), .irq_ack_o(ack), .pc_o(pc_o), .msr_o(msr_o),
    .link_we_o(lwe), .link_idx_o(lidx), .link_val_o(lval),
    .esr_we_o(ewe), .esr_o(esr_o), .btr_we_o(bwe), .btr_o(btr_o),
    .ear_we_o(awe), .ear_o(ear_o), .resv_clr_o(rclr), .iflags_clr_o(fclr)
  );

  typedef struct {
    string       tag;
    logic        take, ack, lwe, ewe, bwe, awe;
    logic [31:0] pc, msr, lval, esr, btr, ear;
    logic [4:0]  lidx;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model written from the requirements
  function automatic exp_t model(string tag);
    exp_t e;
    int   kind; // 0 none, 1 mmu, 2 hwx, 3 brk, 4 irq
    logic irq_ok;
    logic [31:0] m;
    e.tag = tag;
    irq_ok = irq && msr[1] && !msr[9] && !msr[3] && !ds && !imm;
    if (mmu) kind = 1;
    else if (hwx && exc_en) kind = 2;
    else if (brk) kind = 3;
    else if (irq_ok) kind = 4;
    else kind = 0;
    e.take = (kind != 0);
    e.ack  = (kind == 4);
    e.lwe  = e.take;
    e.ewe  = (kind == 1) || (kind == 2);
    e.bwe  = e.ewe && ds;
    e.awe  = (kind == 1);
    e.btr  = btarget;
    e.ear  = faddr;
    m = msr;
    case (kind)
      1, 2: m = m | 32'h0000_0200;
      3:    m = m | 32'h0000_0008;
      4:    m = m & ~32'h0000_0002;
      default: ;
    endcase
    e.msr = (m & ~32'h0000_7800) | ((m & 32'h0000_2800) << 1);
    case (kind)
      1: begin
        e.pc = vec_base + 32'h20; e.lidx = 5'd17;
        e.lval = ds ? (bimm ? pc - 32'd8 : pc - 32'd4) : (imm ? pc - 32'd4 : pc);
        e.esr = (ifetch ? (miss ? 32'd19 : 32'd17) : (miss ? 32'd18 : 32'd16))
                + (store ? 32'h400 : 32'h0) + (ds ? 32'h1000 : 32'h0);
      end
      2: begin
        e.pc = vec_base + 32'h20; e.lidx = 5'd17; e.lval = pc + 32'd4;
        e.esr = ds ? (esr | 32'h1000) : (esr & ~32'h1000);
      end
      3: begin e.pc = vec_base + 32'h18; e.lidx = 5'd16; e.lval = pc; e.esr = 0; end
      4: begin e.pc = vec_base + 32'h10; e.lidx = 5'd14; e.lval = pc; e.esr = 0; end
      default: begin e.pc = 0; e.lidx = 0; e.lval = 0; e.esr = 0; end
    endcase
    return e;
  endfunction

  task automatic drive(string tag, logic c_mmu, logic c_hwx, logic c_brk, logic c_irq,
                       logic [31:0] p, logic [31:0] m, logic d, logic i, logic b);
    @(negedge clk);
    mmu = c_mmu; hwx = c_hwx; brk = c_brk; irq = c_irq;
    pc = p; msr = m; ds = d; imm = i; bimm = b;
    exp_q.push_back(model(tag));
  endtask

  // Monitor: compares results one edge after each drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        checks++;
        bad = (take !== e.take) || (ack !== e.ack) || (lwe !== e.lwe) || (ewe !== e.ewe)
           || (bwe !== e.bwe) || (awe !== e.awe) || (rclr !== e.take) || (fclr !== e.take);
        if (e.take)
          bad = bad || (pc_o !== e.pc) || (msr_o !== e.msr) || (lidx !== e.lidx)
             || (lval !== e.lval);
        if (e.ewe) bad = bad || (esr_o !== e.esr);
        if (e.bwe) bad = bad || (btr_o !== e.btr);
        if (e.awe) bad = bad || (ear_o !== e.ear);
        if (bad) begin
          fails++;
          $display("FAIL %s act: take=%b ack=%b en=%b%b%b%b pc=%h msr=%h l%0d=%h esr=%h btr=%h ear=%h exp: take=%b ack=%b en=%b%b%b%b pc=%h msr=%h l%0d=%h esr=%h btr=%h ear=%h",
            e.tag, take, ack, lwe, ewe, bwe, awe, pc_o, msr_o, lidx, lval, esr_o, btr_o, ear_o,
            e.take, e.ack, e.lwe, e.ewe, e.bwe, e.awe, e.pc, e.msr, e.lidx, e.lval, e.esr, e.btr, e.ear);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_base = 32'h0000_0000; exc_en = 1'b1;
    mmu = 0; hwx = 0; brk = 0; irq = 0; pc = 0; msr = 0; esr = 32'h0000_1005;
    ds = 0; imm = 0; bimm = 0; btarget = 32'h0000_4444; faddr = 32'hDEAD_0010;
    ifetch = 0; miss = 0; store = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (take !== 0 || lwe !== 0 || ewe !== 0 || bwe !== 0 || awe !== 0 || rclr !== 0 || fclr !== 0) begin
      fails++;
      $display("FAIL R11 reset act=%b%b%b%b%b%b%b exp=0000000", take, lwe, ewe, bwe, awe, rclr, fclr);
    end
    rst_n = 1'b1;
    // R1 R2 R5: hardware exception, both modes on
    drive("R2_hwx_plain", 0, 1, 0, 0, 32'h0000_1000, 32'h0000_2802, 0, 0, 0);
    // R6: hardware exception in delay slot
    drive("R6_hwx_ds", 0, 1, 0, 0, 32'h0000_2000, 32'h0000_0800, 1, 0, 0);
    // R7 R3: fetch protection, plain
    ifetch = 1; miss = 0; store = 0;
    drive("R7_mmu_fetch_prot", 1, 0, 0, 0, 32'h0000_3000, 32'h0000_2000, 0, 0, 0);
    // R7 R3: data protection store after prefix
    @(negedge clk); ifetch = 0; store = 1; mmu = 0;
    drive("R3_mmu_store_imm", 1, 0, 0, 0, 32'h0000_3100, 32'h0, 0, 1, 0);
    // R3 R6: fetch miss in delay slot with branch-immediate
    @(negedge clk); ifetch = 1; miss = 1; store = 0; mmu = 0;
    drive("R3_mmu_ds_bimm", 1, 0, 0, 0, 32'h0000_3200, 32'h0000_2800, 1, 0, 1);
    // R3 R7: data miss in delay slot
    @(negedge clk); ifetch = 0; miss = 1; mmu = 0;
    drive("R3_mmu_ds", 1, 0, 0, 0, 32'h0000_3300, 32'h0, 1, 0, 0);
    // R8 R4: interrupt accepted
    drive("R8_irq_ok", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_2802, 0, 0, 0);
    // R8: interrupt blocked by each condition
    drive("R8_irq_no_ie", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_0000, 0, 0, 0);
    drive("R8_irq_eip", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_0202, 0, 0, 0);
    drive("R8_irq_bip", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_000A, 0, 0, 0);
    drive("R8_irq_ds", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_0002, 1, 0, 0);
    drive("R8_irq_imm", 0, 0, 0, 1, 32'h0000_5000, 32'h0000_0002, 0, 1, 0);
    // R4 R2: break
    drive("R4_brk", 0, 0, 1, 0, 32'h0000_6000, 32'h0000_0802, 0, 0, 0);
    // R9: priority
    drive("R9_all", 1, 1, 1, 1, 32'h0000_7000, 32'h0000_0002, 0, 0, 0);
    drive("R9_hwx_brk", 0, 1, 1, 1, 32'h0000_7100, 32'h0000_0002, 0, 0, 0);
    drive("R9_brk_irq", 0, 0, 1, 1, 32'h0000_7200, 32'h0000_0002, 0, 0, 0);
    // R10: exceptions not implemented
    @(negedge clk); exc_en = 0; mmu = 0; hwx = 0; brk = 0; irq = 0;
    drive("R10_hwx_off", 0, 1, 0, 0, 32'h0000_8000, 32'h0000_0002, 0, 0, 0);
    drive("R10_hwx_off_brk", 0, 1, 1, 0, 32'h0000_8100, 32'h0000_0002, 0, 0, 0);
    @(negedge clk); exc_en = 1; mmu = 0; hwx = 0; brk = 0; irq = 0;
    // R1: new vector base
    @(negedge clk); vec_base = 32'hFFFF_0100;
    drive("R1_base_irq", 0, 0, 0, 1, 32'h0000_9000, 32'h0000_0002, 0, 0, 0);
    drive("R1_base_hwx", 0, 1, 0, 0, 32'h0000_9100, 32'h0000_6002, 0, 0, 0);
    // R11: idle
    drive("R11_idle", 0, 0, 0, 0, 32'h0000_A000, 32'h0000_0002, 0, 0, 0);
    drive("R11_idle2", 0, 0, 0, 0, 32'h0000_A000, 32'h0000_0002, 0, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule